// File: doc/BRIEF.md
# Dual-LED Blink Sequencer

This block drives two status LEDs from a slow periodic tick strobe. The first LED beats like a pulse: within each period it lights twice, once at the start and once a quarter of the period later, and each flash lasts a fixed number of ticks. The period comes from an 8-bit load input that an external agent computes; the block reads that input only at the moment one period ends and the next begins, so every beat is timed consistently. The second LED plays a fixed message pattern held in an internal read-only table. Each table byte carries a light level and a duration multiplier, and a terminator byte sends playback back to the start.

The tick input is a plain strobe, not a stream: there is no valid/ready handshake and no back-pressure, because the sequencer can always absorb a tick in a single cycle. On clock cycles where the tick is low, nothing in the block changes state. The table content is computed from a message word parameter: every message bit, least significant first, becomes a lit entry (long when the bit is 1, short when it is 0) followed by a short dark gap, and a terminator closes the table.

Top module: `led_blink_seq`

## Requirements
- R1: After reset both LEDs are off, the message pointer and hold counter are zero, and the heartbeat uses a period of 126 ticks with its second pulse at count 31.
- R2: On a clock cycle where `tick` is low, neither LED nor any internal counter changes.
- R3: A table byte encodes the LED level in bit 4 and a duration multiplier in bits 3:0; when a byte is fetched on a tick, the hold counter is loaded with 10 times the multiplier and decrements once per tick, and the next byte is fetched on the first tick that finds the counter at zero, so a byte holds the level for 10*multiplier+1 ticks.
- R4: A byte of 0xFF is a terminator: on fetching it the sequencer uses entry 0 on that same tick and continues from entry 1.
- R5: On a tick where the heartbeat count equals 0 or the quarter offset, the heartbeat LED turns on; otherwise, on a tick where the count equals 7 or the quarter offset plus 7, it turns off; turning on takes priority.
- R6: The heartbeat count rises by one per tick; when the raised value would exceed the current period, the count returns to 0, a new period is latched, and the quarter offset becomes the new period divided by 4 (rounded down).
- R7: `period_in` is sampled only on the wrap tick of R6; changes at any other time do not affect the running period.
- R8: A sampled period is clamped into the range 30 to 126 ticks.
- R9: The table holds, for message bit k, entry 2k = level 1 with multiplier 3 if the bit is 1 or 1 if it is 0, entry 2k+1 = level 0 with multiplier 1, and entry 2*MSG_BITS = 0xFF; the default message word is 0xB5 with 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sequencer advance strobe, one clock wide per step |
| period_in | input | 8 | Heartbeat period in ticks, sampled at period wrap |
| hb_led | output | 1 | Heartbeat LED, 1 = lit |
| msg_led | output | 1 | Message pattern LED, 1 = lit |

## Verification
Every cycle the assertions check that idle cycles freeze both LEDs and the counters, that a held table byte keeps its level, that a terminator fetch restarts at entry 1, that the heartbeat count never passes the period, that the latched period stays inside its clamp range and only moves on a wrap, and that the pulse edges fall at counts 0 and 7. Only the bench's scenarios can show the full sequences: the exact message played over a wrap of the table, the spacing of the two pulses for different periods, clamping of out-of-range load values, and that load changes in mid-period are ignored under both dense and sparse ticks.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
  typedef logic [7:0] pat_byte_t;
  localparam pat_byte_t PAT_TERM  = 8'hFF;
  localparam int        LEVEL_POS = 4;
  localparam int        MULT_W    = 4;
  localparam int        MULT_MAX  = (1 << MULT_W) - 1;

  function automatic pat_byte_t pack_entry(input logic level, input logic [MULT_W-1:0] mult);
    pat_byte_t b;
    b = '0;
    b[LEVEL_POS] = level;
    b[MULT_W-1:0] = mult;
    return b;
  endfunction
endpackage

// File: rtl/led_pattern_rom.sv
module led_pattern_rom
  import led_seq_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int MSG_BITS = 8,
  parameter logic [MSG_BITS-1:0] MSG_WORD = '0,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] rd_addr,
  output pat_byte_t         rd_data,
  output pat_byte_t         first_data
);
  pat_byte_t table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i >= 2 * MSG_BITS) begin : g_term
      assign table_q[i] = PAT_TERM;
    end else if ((i % 2) == 1) begin : g_gap
      assign table_q[i] = pack_entry(1'b0, MULT_W'(1));
    end else begin : g_mark
      assign table_q[i] = pack_entry(1'b1, MSG_WORD[i/2] ? MULT_W'(3) : MULT_W'(1));
    end
  end

  assign rd_data    = table_q[rd_addr];
  assign first_data = table_q[0];
endmodule

// File: rtl/led_pattern_player.sv
module led_pattern_player
  import led_seq_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int HOLD_SCALE = 10,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int HOLD_MAX  = MULT_MAX * HOLD_SCALE,
  localparam int HOLD_W    = $clog2(HOLD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  pat_byte_t         rd_data,
  input  pat_byte_t         first_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              led
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              led_q, led_d;
  pat_byte_t         entry;
  logic              is_term;

  assign is_term = (rd_data == PAT_TERM);
  assign entry   = is_term ? first_data : rd_data;

  always_comb begin
    ptr_d  = ptr_q;
    hold_d = hold_q;
    led_d  = led_q;
    if (tick) begin
      if (hold_q != '0) begin
        hold_d = hold_q - HOLD_W'(1);
      end else begin
        ptr_d  = is_term ? ADDR_W'(1) : ptr_q + ADDR_W'(1);
        led_d  = entry[LEVEL_POS];
        hold_d = HOLD_W'(entry[MULT_W-1:0]) * HOLD_W'(HOLD_SCALE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      hold_q <= '0;
      led_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      hold_q <= hold_d;
      led_q  <= led_d;
    end
  end

  assign rd_addr = ptr_q;
  assign led     = led_q;

  a_r2_player_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ptr_q) && $stable(hold_q) && $stable(led_q)));
  a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hold_q != '0) |=> ($stable(led_q) && $stable(ptr_q)));
  a_r3_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= HOLD_W'(HOLD_MAX));
  a_r4_term_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hold_q == '0 && rd_data == PAT_TERM) |=> (ptr_q == ADDR_W'(1)));
endmodule

// File: rtl/led_heartbeat.sv
module led_heartbeat #(
  parameter int PERIOD_W   = 8,
  parameter int MIN_PERIOD = 30,
  parameter int MAX_PERIOD = 126,
  parameter int ON_TICKS   = 7,
  localparam int CNT_W     = PERIOD_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period_in,
  output logic                led
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic [PERIOD_W-1:0] period_q, period_d;
  logic [PERIOD_W-1:0] dist_q, dist_d;
  logic                led_q, led_d;
  logic [CNT_W-1:0]    cnt_inc;
  logic [PERIOD_W-1:0] clamped;
  logic                on_hit, off_hit;

  always_comb begin
    if (period_in < PERIOD_W'(MIN_PERIOD))      clamped = PERIOD_W'(MIN_PERIOD);
    else if (period_in > PERIOD_W'(MAX_PERIOD)) clamped = PERIOD_W'(MAX_PERIOD);
    else                                        clamped = period_in;
  end

  assign cnt_inc = {1'b0, cnt_q} + CNT_W'(1);
  assign on_hit  = (cnt_q == '0) || (cnt_q == dist_q);
  assign off_hit = ({1'b0, cnt_q} == CNT_W'(ON_TICKS)) ||
                   ({1'b0, cnt_q} == ({1'b0, dist_q} + CNT_W'(ON_TICKS)));

  always_comb begin
    cnt_d    = cnt_q;
    period_d = period_q;
    dist_d   = dist_q;
    led_d    = led_q;
    if (tick) begin
      if (on_hit)       led_d = 1'b1;
      else if (off_hit) led_d = 1'b0;
      if (cnt_inc > {1'b0, period_q}) begin
        cnt_d    = '0;
        period_d = clamped;
        dist_d   = clamped >> 2;
      end else begin
        cnt_d = cnt_inc[PERIOD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      period_q <= PERIOD_W'(MAX_PERIOD);
      dist_q   <= PERIOD_W'(MAX_PERIOD / 4);
      led_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      period_q <= period_d;
      dist_q   <= dist_d;
      led_q    <= led_d;
    end
  end

  assign led = led_q;

  a_r2_beat_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_q) && $stable(led_q) && $stable(period_q)));
  a_r5_on_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0) |=> led_q);
  a_r5_off_at_width: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == PERIOD_W'(ON_TICKS) && cnt_q != dist_q) |=> !led_q);
  a_r6_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_q);
  a_r7_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || cnt_q != period_q) |=> $stable(period_q));
  a_r8_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q >= PERIOD_W'(MIN_PERIOD)) && (period_q <= PERIOD_W'(MAX_PERIOD)));
endmodule

// File: rtl/led_blink_seq.sv
module led_blink_seq
  import led_seq_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int MIN_PERIOD = 30,
  parameter int MAX_PERIOD = 126,
  parameter int ON_TICKS   = 7,
  parameter int HOLD_SCALE = 10,
  parameter int ROM_DEPTH  = 128,
  parameter int MSG_BITS   = 8,
  parameter logic [MSG_BITS-1:0] MSG_WORD = 8'hB5,
  localparam int ADDR_W    = $clog2(ROM_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period_in,
  output logic                hb_led,
  output logic                msg_led
);
  logic [ADDR_W-1:0] rom_addr;
  pat_byte_t         rom_data;
  pat_byte_t         rom_first;

  led_heartbeat #(
    .PERIOD_W  (PERIOD_W),
    .MIN_PERIOD(MIN_PERIOD),
    .MAX_PERIOD(MAX_PERIOD),
    .ON_TICKS  (ON_TICKS)
  ) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .period_in(period_in),
    .led      (hb_led)
  );

  led_pattern_rom #(
    .DEPTH   (ROM_DEPTH),
    .MSG_BITS(MSG_BITS),
    .MSG_WORD(MSG_WORD)
  ) u_rom (
    .rd_addr   (rom_addr),
    .rd_data   (rom_data),
    .first_data(rom_first)
  );

  led_pattern_player #(
    .DEPTH     (ROM_DEPTH),
    .HOLD_SCALE(HOLD_SCALE)
  ) u_player (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rd_data   (rom_data),
    .first_data(rom_first),
    .rd_addr   (rom_addr),
    .led       (msg_led)
  );

  a_r9_first_is_mark: assert property (@(posedge clk) disable iff (!rst_n)
    rom_first[LEVEL_POS] && (rom_first != PAT_TERM));
endmodule

// File: tb/led_blink_seq_tb_top.sv
`timescale 1ns/1ps
module led_blink_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] period_in = 8'd126;
  logic       hb_led, msg_led;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  led_blink_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_in(period_in),
    .hb_led(hb_led), .msg_led(msg_led)
  );

  // Behavioural reference state
  int m_cnt = 0, m_per = 126, m_dist = 31, m_ptr = 0, m_hold = 0;
  bit m_hb = 0, m_msg = 0;
  localparam bit [7:0] MSG = 8'hB5;

  function automatic int table_at(int idx);
    if (idx >= 16) return 255;
    if (idx % 2 == 1) return 1;
    return MSG[idx/2] ? 16 + 3 : 16 + 1;
  endfunction

  function automatic int clamp(int p);
    if (p < 30) return 30;
    if (p > 126) return 126;
    return p;
  endfunction

  task automatic model_tick(int pin);
    int e;
    if (m_cnt == 0 || m_cnt == m_dist) m_hb = 1;
    else if (m_cnt == 7 || m_cnt == m_dist + 7) m_hb = 0;
    m_cnt++;
    if (m_cnt > m_per) begin
      m_cnt = 0; m_per = clamp(pin); m_dist = m_per / 4;
    end
    if (m_hold > 0) m_hold--;
    else begin
      e = table_at(m_ptr);
      if (e == 255) begin m_ptr = 0; e = table_at(0); end
      m_ptr++;
      m_msg = e[4];
      m_hold = 10 * (e % 16);
    end
  endtask

  task automatic check(bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL [%s] %s actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // mode 0: every cycle, 1: every third cycle, 2: random
  task automatic run_phase(string t, int mode, int cycles, int p0, int p1);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      tag = t;
      check(hb_led, m_hb, "hb_led");
      check(msg_led, m_msg, "msg_led");
      period_in = (i % 2 == 0) ? 8'(p0) : 8'(p1);
      case (mode)
        0: tick = 1'b1;
        1: tick = (i % 3 == 0);
        default: tick = 1'($urandom % 2);
      endcase
      if (tick) model_tick(int'(period_in));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state before any tick
    @(negedge clk);
    tag = "R1";
    check(hb_led, 1'b0, "hb_led after reset");
    check(msg_led, 1'b0, "msg_led after reset");
    // R1 R3 R4 R5 R6 R9: dense ticks, nominal period, full table wrap
    run_phase("R1 R3 R4 R5 R6 R9", 0, 900, 126, 126);
    // R7: load input toggles every cycle, used only at wraps
    run_phase("R7 R6", 0, 600, 40, 90);
    // R8: below and above the clamp range
    run_phase("R8 low", 0, 300, 5, 5);
    run_phase("R8 high", 0, 400, 250, 250);
    // R2: sparse and random ticks
    run_phase("R2 R5", 1, 1500, 60, 60);
    run_phase("R2 R3 R4", 2, 2000, 33, 100);
    tick = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL [watchdog] run incomplete actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule